// File: doc/BRIEF.md
# Receive-Idle Timeout Counter/Timer

This block is a 16-bit down-counter shared by two serial receive channels. It runs in one of three ways. As a one-shot counter it counts down from a preload value, raises a ready flag and drives its output low when it reaches zero. As a square-wave timer it reloads and flips its output every n counter clocks. This gives a baud-rate reference with n = clock / (32 × baud). In receive time-out mode, each character a channel moves into its receive FIFO restarts the count. The ready flag, and with it the interrupt, is raised only once the incoming stream has been quiet for the programmed interval.

The preload value is written one byte at a time. The counter advances only on cycles where the counter-clock enable `tick` is high. Time-out mode is switched on and off per channel by command codes. While it is on for any channel, it takes over from the ordinary start and stop commands. The live count can be read at any time, one byte at a time.

Top module: `rxidle_ctimer`

## Requirements
- R1: After reset the ready flag and `irq` are low, `ct_out` is high, the live count reads 0 in both bytes, and time-out mode is off for both channels.
- R2: `hi_we` and `lo_we` write `wr_byte` into the upper or lower byte of the preload. The count itself changes only on a start command or a tick. `rd_data` returns the live count: the upper byte when `rd_hi` is 1 and the lower byte when it is 0.
- R3: In one-shot mode (`run_square` = 0, time-out off), a start loads the preload and each tick decrements it. On the tick that takes the count from 1 to 0, `ready` goes high and `ct_out` goes low. A preload of 0 also expires on its first tick.
- R4: After expiry the count wraps from 0 to 0xFFFF and keeps decrementing on each tick, with no further change to `ready` or `ct_out`.
- R5: A stop command halts the count and clears `ready`. A start command reloads the preload, sets `ct_out` high and runs.
- R6: In square mode (`run_square` = 1, time-out off), `ct_out` inverts every n ticks for a preload n ≥ 1, and on every tick for a preload of 0 or 1. Square mode leaves `ready` unchanged.
- R7: On a channel's `cmd_we` bit, code 0xA turns time-out mode on for that channel, clears `ready` and stops the count until a character arrives. Code 0xC turns it off for that channel. Any other code has no effect.
- R8: While time-out mode is on for any channel, the start and stop commands are ignored.
- R9: A `rx_load` pulse on a channel with time-out on stops the count. The next tick reloads the preload without decrementing, and later ticks decrement. The n-th tick after the reload tick sets `ready` and drives `ct_out` low. A `rx_load` pulse on a channel with time-out off has no effect.
- R10: A `rx_load` pulse on an enabled channel after expiry clears `ready` and `irq` and sets `ct_out` high again.
- R11: With time-out on for both channels, a character on either channel restarts the count, so expiry needs both receivers to be idle for the whole interval.
- R12: `irq` is high exactly when `ready` and `irq_mask` are both high.
- R13: When events coincide in one cycle, a 0xA command takes precedence over a character restart, a restart over start/stop, and start/stop over a tick. Stop takes precedence over start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Counter clock enable, one system cycle per event |
| hi_we | input | 1 | Write `wr_byte` into the upper preload byte |
| lo_we | input | 1 | Write `wr_byte` into the lower preload byte |
| wr_byte | input | 8 | Preload write data |
| run_square | input | 1 | 1 selects square-wave timer, 0 one-shot counter |
| start_cmd | input | 1 | Start command pulse |
| stop_cmd | input | 1 | Stop command pulse |
| cmd_we | input | 2 | Per-channel command write strobe |
| cmd_code | input | 4 | Command code (0xA on, 0xC off) |
| rx_load | input | 2 | Per-channel character-loaded-into-FIFO strobe |
| irq_mask | input | 1 | Interrupt enable for the ready flag |
| rd_hi | input | 1 | Read byte select, 1 for the upper byte |
| rd_data | output | 8 | Selected byte of the live count |
| ready | output | 1 | Counter-ready flag |
| irq | output | 1 | Masked interrupt request |
| ct_out | output | 1 | Counter/timer output |

## Verification
The one-shot count is driven with a small preload, with a zero preload and through a long wrap. These show whether expiry comes on the exact tick and whether the wrap stays silent. Square mode is tried with preloads of 3 and 1, which separates a reload-every-n period from an off-by-one period. The time-out path is driven with character streams that have gaps, with loads on a disabled channel, with loads alternating between two enabled channels and with events that coincide. These tell apart reload timing, per-channel gating, OR-ed restart and the order of precedence. A long random stretch then mixes every input against the reference model.

// File: rtl/rxidle_ctimer_pkg.sv
// Shared command codes and run-style type for the receive-idle counter/timer.
package rxidle_ctimer_pkg;
    localparam logic [3:0] CMD_TO_ON  = 4'hA;
    localparam logic [3:0] CMD_TO_OFF = 4'hC;

    typedef enum logic {
        RUN_ONESHOT = 1'b0,
        RUN_SQUARE  = 1'b1
    } run_style_e;
endpackage

// File: rtl/ct_preload.sv
// Preload holder: two byte-wide halves written separately.
// Assumes CNT_W is even; writes take effect on the next clock.
module ct_preload #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hi_we,
    input  logic               lo_we,
    input  logic [CNT_W/2-1:0] wr_byte,
    output logic [CNT_W-1:0]   preload
);
    localparam int HALF = CNT_W / 2;

    // Capture each half on its own write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload <= '0;
        end else begin
            if (hi_we) preload[CNT_W-1:HALF] <= wr_byte;
            if (lo_we) preload[HALF-1:0]     <= wr_byte;
        end
    end
endmodule

// File: rtl/ct_tomode.sv
// Per-channel receive time-out enables and the events they produce.
// arm: any channel received the turn-on code this cycle.
// restart: a character arrived on a channel whose enable was already set.
module ct_tomode
    import rxidle_ctimer_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CMD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   cmd_we,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic [NCH-1:0]   rx_load,
    output logic [NCH-1:0]   to_en,
    output logic             to_active,
    output logic             arm,
    output logic             restart
);
    logic [NCH-1:0] arm_vec;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        // Decode this channel's on-command.
        assign arm_vec[c] = cmd_we[c] && (cmd_code == CMD_W'(CMD_TO_ON));

        // Hold the channel's time-out enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                to_en[c] <= 1'b0;
            end else if (cmd_we[c]) begin
                if (cmd_code == CMD_W'(CMD_TO_ON))
                    to_en[c] <= 1'b1;
                else if (cmd_code == CMD_W'(CMD_TO_OFF))
                    to_en[c] <= 1'b0;
            end
        end
    end

    assign arm       = |arm_vec;
    assign restart   = |(rx_load & to_en);
    assign to_active = |to_en;
endmodule

// File: rtl/ct_core.sv
// Down-counter core. One-shot style flags the first arrival at zero and then
// wraps silently; square style reloads and inverts the output every n ticks.
// Assumes start/stop are already gated by the caller and that the event
// priority is arm > restart > stop > start > tick.
module ct_core
    import rxidle_ctimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             arm,
    input  logic             restart,
    input  logic             start,
    input  logic             stop,
    input  run_style_e       style,
    input  logic [CNT_W-1:0] preload,
    output logic [CNT_W-1:0] count,
    output logic             ready,
    output logic             ct_out
);
    logic running;
    logic reload_pend;
    logic fired;
    logic at_end;

    // Count is at its last step when it holds 0 or 1.
    assign at_end = (count <= CNT_W'(1));

    // Sequence the counter, flag and output by event priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count       <= '0;
            running     <= 1'b0;
            reload_pend <= 1'b0;
            fired       <= 1'b0;
            ready       <= 1'b0;
            ct_out      <= 1'b1;
        end else if (arm) begin
            running     <= 1'b0;
            reload_pend <= 1'b0;
            fired       <= 1'b0;
            ready       <= 1'b0;
            ct_out      <= 1'b1;
        end else if (restart) begin
            running     <= 1'b0;
            reload_pend <= 1'b1;
            fired       <= 1'b0;
            ready       <= 1'b0;
            ct_out      <= 1'b1;
        end else if (stop) begin
            running     <= 1'b0;
            reload_pend <= 1'b0;
            ready       <= 1'b0;
        end else if (start) begin
            count       <= preload;
            running     <= 1'b1;
            reload_pend <= 1'b0;
            fired       <= 1'b0;
            ct_out      <= 1'b1;
        end else if (tick) begin
            if (reload_pend) begin
                count       <= preload;
                running     <= 1'b1;
                reload_pend <= 1'b0;
            end else if (running) begin
                if (style == RUN_ONESHOT) begin
                    count <= count - 1'b1;
                    if (!fired && at_end) begin
                        fired  <= 1'b1;
                        ready  <= 1'b1;
                        ct_out <= 1'b0;
                    end
                end else if (at_end) begin
                    count  <= preload;
                    ct_out <= ~ct_out;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rxidle_ctimer.sv
// Top of the receive-idle counter/timer: preload bytes, per-channel time-out
// control and the shared down-counter, plus a byte-wide live read port.
// Assumes tick is a single-cycle enable in the clk domain.
module rxidle_ctimer
    import rxidle_ctimer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 2,
    parameter int CMD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               hi_we,
    input  logic               lo_we,
    input  logic [CNT_W/2-1:0] wr_byte,
    input  logic               run_square,
    input  logic               start_cmd,
    input  logic               stop_cmd,
    input  logic [NCH-1:0]     cmd_we,
    input  logic [CMD_W-1:0]   cmd_code,
    input  logic [NCH-1:0]     rx_load,
    input  logic               irq_mask,
    input  logic               rd_hi,
    output logic [CNT_W/2-1:0] rd_data,
    output logic               ready,
    output logic               irq,
    output logic               ct_out
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] preload;
    logic [CNT_W-1:0] cnt_live;
    logic [NCH-1:0]   to_en;
    logic             to_active;
    logic             arm;
    logic             restart;
    logic             start_ok;
    logic             stop_ok;
    run_style_e       style;

    ct_preload #(.CNT_W(CNT_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .hi_we(hi_we), .lo_we(lo_we),
        .wr_byte(wr_byte), .preload(preload)
    );

    ct_tomode #(.NCH(NCH), .CMD_W(CMD_W)) u_to (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .rx_load(rx_load), .to_en(to_en), .to_active(to_active),
        .arm(arm), .restart(restart)
    );

    // Time-out mode overrides the plain commands and forces one-shot style.
    assign start_ok = start_cmd && !to_active;
    assign stop_ok  = stop_cmd && !to_active;
    assign style    = (run_square && !to_active) ? RUN_SQUARE : RUN_ONESHOT;

    ct_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .arm(arm), .restart(restart),
        .start(start_ok), .stop(stop_ok), .style(style), .preload(preload),
        .count(cnt_live), .ready(ready), .ct_out(ct_out)
    );

    // Byte-select the live count for the read port.
    assign rd_data = rd_hi ? cnt_live[CNT_W-1:HALF] : cnt_live[HALF-1:0];
    assign irq     = ready & irq_mask;
endmodule

// File: rtl/rxidle_ctimer_chk.sv
// Assertion checker for rxidle_ctimer, attached by bind below.
// Assumes the core's event priority: arm > restart > stop > start > tick.
module rxidle_ctimer_chk #(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             start_cmd,
    input logic [NCH-1:0]   rx_load,
    input logic [NCH-1:0]   to_en,
    input logic [CNT_W-1:0] cnt_live,
    input logic             ready,
    input logic             ct_out
);
    // R3
    ready_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(tick));

    // R3
    ready_out_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> !ct_out);

    // R10
    char_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rx_load & to_en)) |=> !ready);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|to_en) && start_cmd && !tick) |=> $stable(cnt_live));

    // R2
    count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start_cmd) |=> $stable(cnt_live));
endmodule

bind rxidle_ctimer rxidle_ctimer_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_cmd(start_cmd),
    .rx_load(rx_load), .to_en(to_en), .cnt_live(cnt_live),
    .ready(ready), .ct_out(ct_out)
);

// File: tb/rxidle_ctimer_bench.sv
module rxidle_ctimer_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       tick = 0, hi_we = 0, lo_we = 0, run_square = 0;
    logic [7:0] wr_byte = 0;
    logic       start_cmd = 0, stop_cmd = 0, irq_mask = 0, rd_hi = 0;
    logic [1:0] cmd_we = 0, rx_load = 0;
    logic [3:0] cmd_code = 0;
    logic [7:0] rd_data;
    logic       ready, irq, ct_out;

    int    checks = 0, fails = 0;
    string cur_req = "R1";
    bit    done = 0;

    // behavioural reference state
    int m_cnt, m_pre;
    bit m_run, m_pend, m_fired, m_rdy, m_out;
    bit [1:0] m_to;
    bit m_arm, m_rs, m_toact;

    always #4 clk = ~clk;

    rxidle_ctimer u_rxidle_ctimer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hi_we(hi_we), .lo_we(lo_we),
        .wr_byte(wr_byte), .run_square(run_square), .start_cmd(start_cmd),
        .stop_cmd(stop_cmd), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .rx_load(rx_load), .irq_mask(irq_mask), .rd_hi(rd_hi),
        .rd_data(rd_data), .ready(ready), .irq(irq), .ct_out(ct_out)
    );

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_run = 0; m_pend = 0; m_fired = 0;
            m_rdy = 0; m_out = 1; m_to = 0;
        end else begin
            m_toact = (m_to != 0);
            m_arm = 0; m_rs = 0;
            for (int c = 0; c < 2; c++) begin
                if (cmd_we[c] && cmd_code == 4'hA) m_arm = 1;
                if (rx_load[c] && m_to[c]) m_rs = 1;
            end
            if (m_arm) begin
                m_run = 0; m_pend = 0; m_rdy = 0; m_out = 1; m_fired = 0;
            end else if (m_rs) begin
                m_run = 0; m_pend = 1; m_rdy = 0; m_out = 1; m_fired = 0;
            end else if (!m_toact && stop_cmd) begin
                m_run = 0; m_pend = 0; m_rdy = 0;
            end else if (!m_toact && start_cmd) begin
                m_cnt = m_pre; m_run = 1; m_pend = 0; m_fired = 0; m_out = 1;
            end else if (tick) begin
                if (m_pend) begin
                    m_cnt = m_pre; m_run = 1; m_pend = 0;
                end else if (m_run) begin
                    if (m_toact || !run_square) begin
                        if (!m_fired && m_cnt <= 1) begin
                            m_rdy = 1; m_out = 0; m_fired = 1;
                        end
                        m_cnt = (m_cnt == 0) ? 65535 : m_cnt - 1;
                    end else if (m_cnt <= 1) begin
                        m_cnt = m_pre; m_out = !m_out;
                    end else begin
                        m_cnt = m_cnt - 1;
                    end
                end
            end
            for (int c = 0; c < 2; c++) begin
                if (cmd_we[c] && cmd_code == 4'hA) m_to[c] = 1;
                else if (cmd_we[c] && cmd_code == 4'hC) m_to[c] = 0;
            end
            if (hi_we) m_pre = (int'(wr_byte) << 8) | (m_pre & 255);
            if (lo_we) m_pre = (m_pre & 65280) | int'(wr_byte);
        end
    end

    // compare outputs against the model on every clock, away from the edge
    always @(negedge clk) begin
        int exp_rd;
        if (rst_n && !done) begin
            exp_rd = rd_hi ? (m_cnt >> 8) : (m_cnt & 255);
            checks++;
            if (ready !== m_rdy || ct_out !== m_out ||
                irq !== (m_rdy & irq_mask) || int'(rd_data) != exp_rd) begin
                fails++;
                $display("FAIL %s model: rdy=%0b out=%0b irq=%0b rd=%0h exp rdy=%0b out=%0b irq=%0b rd=%0h",
                         cur_req, ready, ct_out, irq, rd_data, m_rdy, m_out,
                         m_rdy & irq_mask, exp_rd);
            end
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic ticks(int n);
        tick = 1; repeat (n) step(); tick = 0;
    endtask

    task automatic write_pre(logic [7:0] hi, logic [7:0] lo);
        hi_we = 1; wr_byte = hi; step(); hi_we = 0;
        lo_we = 1; wr_byte = lo; step(); lo_we = 0;
    endtask

    task automatic cmd(int ch, logic [3:0] code);
        cmd_we[ch] = 1; cmd_code = code; step(); cmd_we = 0;
    endtask

    task automatic pulse_start(); start_cmd = 1; step(); start_cmd = 0; endtask
    task automatic pulse_stop();  stop_cmd = 1;  step(); stop_cmd = 0;  endtask
    task automatic char_in(int ch); rx_load[ch] = 1; step(); rx_load = 0; endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_byte(string req, bit hi, int exp);
        rd_hi = hi; #1;
        chk(req, hi ? "count hi" : "count lo", int'(rd_data), exp);
    endtask

    // watchdog: a hung run still reaches the summary
    initial begin
        #(8 * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1; step();
        // R1 reset state
        cur_req = "R1";
        chk("R1", "ready", ready, 0);
        chk("R1", "ct_out", ct_out, 1);
        chk("R1", "irq", irq, 0);
        chk_byte("R1", 1, 0);
        chk_byte("R1", 0, 0);

        // R2 preload bytes and live read
        cur_req = "R2";
        write_pre(8'h12, 8'h34);
        chk_byte("R2", 0, 0);
        pulse_start();
        chk_byte("R2", 1, 8'h12);
        chk_byte("R2", 0, 8'h34);
        pulse_stop();

        // R3 one-shot expiry timing
        cur_req = "R3";
        write_pre(8'h00, 8'h05);
        pulse_start();
        ticks(4);
        chk("R3", "ready before end", ready, 0);
        chk_byte("R3", 0, 1);
        ticks(1);
        chk("R3", "ready at end", ready, 1);
        chk("R3", "ct_out at end", ct_out, 0);
        chk_byte("R3", 0, 0);

        // R4 silent wrap
        cur_req = "R4";
        ticks(1);
        chk_byte("R4", 1, 8'hFF);
        chk_byte("R4", 0, 8'hFF);
        ticks(300);
        chk("R4", "ready held", ready, 1);
        chk("R4", "ct_out held", ct_out, 0);
        chk_byte("R4", 1, 8'hFE);
        chk_byte("R4", 0, 8'hD3);

        // R5 stop and start
        cur_req = "R5";
        pulse_stop();
        chk("R5", "ready after stop", ready, 0);
        ticks(3);
        chk_byte("R5", 0, 8'hD3);
        pulse_start();
        chk("R5", "ct_out after start", ct_out, 1);
        chk_byte("R5", 0, 5);

        // R3 zero preload expires on first tick
        cur_req = "R3";
        write_pre(8'h00, 8'h00);
        pulse_start();
        ticks(1);
        chk("R3", "zero preload ready", ready, 1);
        chk_byte("R3", 1, 8'hFF);

        // R6 square wave
        cur_req = "R6";
        pulse_stop();
        run_square = 1;
        write_pre(8'h00, 8'h03);
        pulse_start();
        ticks(2);
        chk("R6", "out before n", ct_out, 1);
        ticks(1);
        chk("R6", "out at n", ct_out, 0);
        chk("R6", "ready untouched", ready, 0);
        ticks(3);
        chk("R6", "out at 2n", ct_out, 1);
        write_pre(8'h00, 8'h01);
        pulse_start();
        ticks(1);
        chk("R6", "n=1 first", ct_out, 0);
        ticks(1);
        chk("R6", "n=1 second", ct_out, 1);

        // R7 enable command clears ready and holds the count
        cur_req = "R7";
        run_square = 0;
        write_pre(8'h00, 8'h02);
        pulse_start();
        ticks(2);
        chk("R7", "ready set before arm", ready, 1);
        cmd(0, 4'hA);
        chk("R7", "ready cleared by arm", ready, 0);
        ticks(5);
        chk_byte("R7", 0, 0);

        // R8 start/stop ignored in time-out mode
        cur_req = "R8";
        write_pre(8'h00, 8'h04);
        pulse_start();
        chk_byte("R8", 0, 0);
        pulse_stop();
        chk_byte("R8", 0, 0);

        // R9 character restart timing
        cur_req = "R9";
        char_in(0);
        ticks(1);
        chk_byte("R9", 0, 4);
        ticks(3);
        chk("R9", "no expiry yet", ready, 0);
        chk_byte("R9", 0, 1);
        ticks(1);
        chk("R9", "expiry", ready, 1);
        chk("R9", "ct_out low", ct_out, 0);
        cur_req = "R12";
        chk("R12", "irq masked", irq, 0);
        irq_mask = 1; #1;
        chk("R12", "irq unmasked", irq, 1);

        // R10 late character clears the flag
        cur_req = "R10";
        char_in(0);
        chk("R10", "ready cleared", ready, 0);
        chk("R10", "irq cleared", irq, 0);
        chk("R10", "ct_out high", ct_out, 1);
        ticks(1);
        chk_byte("R10", 0, 4);

        // R9 disabled channel ignored
        cur_req = "R9";
        ticks(2);
        char_in(1);
        ticks(1);
        chk_byte("R9", 0, 1);

        // R11 OR-ed restart across channels
        cur_req = "R11";
        cmd(1, 4'hA);
        for (int i = 0; i < 6; i++) begin
            char_in(i % 2);
            ticks(1);
            ticks(3);
            chk("R11", "no expiry while active", ready, 0);
        end
        ticks(1);
        chk("R11", "expiry after both idle", ready, 1);

        // R7 turn-off command and ignored code
        cur_req = "R7";
        cmd(0, 4'hC);
        cmd(1, 4'hC);
        pulse_start();
        chk_byte("R7", 0, 4);
        cmd(0, 4'h5);
        char_in(0);
        ticks(1);
        chk_byte("R7", 0, 3);

        // R13 coinciding events
        cur_req = "R13";
        cmd(0, 4'hA);
        rx_load[0] = 1; tick = 1; step(); rx_load = 0; tick = 0;
        chk_byte("R13", 0, 3);
        ticks(1);
        chk_byte("R13", 0, 4);
        ticks(2);
        cmd_we[0] = 1; cmd_code = 4'hA; rx_load[0] = 1; step();
        cmd_we = 0; rx_load = 0;
        ticks(1);
        chk_byte("R13", 0, 2);
        chk("R13", "ready after arm", ready, 0);

        // R13 random mix compared against the model each clock
        for (int i = 0; i < 4000; i++) begin
            tick      = ($urandom % 2) == 0;
            rx_load   = {($urandom % 16) == 0, ($urandom % 16) == 0};
            start_cmd = ($urandom % 32) == 0;
            stop_cmd  = ($urandom % 64) == 0;
            cmd_we    = {($urandom % 64) == 0, ($urandom % 64) == 0};
            case ($urandom % 3)
                0: cmd_code = 4'hA;
                1: cmd_code = 4'hC;
                default: cmd_code = 4'($urandom);
            endcase
            hi_we   = ($urandom % 128) == 0;
            lo_we   = ($urandom % 32) == 0;
            wr_byte = hi_we ? 8'h00 : 8'($urandom % 12);
            if (($urandom % 256) == 0) run_square = ~run_square;
            if (($urandom % 8) == 0) irq_mask = ~irq_mask;
            rd_hi = ($urandom % 2) == 0;
            step();
        end
        tick = 0; rx_load = 0; start_cmd = 0; stop_cmd = 0; cmd_we = 0;
        hi_we = 0; lo_we = 0;
        step();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule